// File: doc/BRIEF.md
# ADC Configuration Register Sequencer

This block drives the serial configuration port of an external analog-to-digital converter. When the host asks for initialisation, it pulls the converter's active-low reset line low for a set number of system clock cycles. It then waits out the converter's start-up time and opens its request port. Each host request becomes one or two 16-bit SPI frames. The sequencer drives chip select, serial clock and the data line towards the converter, and it reads the converter's data output line. The serial clock idles low, the converter captures on the rising edge, and outgoing data changes on the falling edge.

A frame has three fields, most significant first: a 4-bit opcode, the register address, and the data byte. The opcode is 0x1 for a write and 0x2 for a read. A read returns the register contents only in the next frame. For a read, the sequencer therefore follows the read command with an all-zero frame on its own and keeps the low byte it shifts in during that frame. The host sees a single-cycle done pulse with the result. The convert-start line is held inactive (high) at all times. Every timing figure is a parameter in system clock cycles and is checked against the converter's limits when the design is elaborated.

Top module: `adc_cfg_seq`

## Requirements
- R1: When the system reset is released, outputs are: converter reset high, chip select high, serial clock low, convert-start high, req_ready low and done low.
- R2: An init_req accepted while uninitialised or idle drives adc_rst_n low for exactly RST_CYC cycles. Chip select stays high and req_ready stays low during that pulse.
- R3: req_ready rises exactly BOOT_CYC cycles after adc_rst_n returns high, and no frame starts before then.
- R4: A frame holds exactly 16 rising serial clock edges. The clock is low whenever chip select is high. Each high phase and each inner low phase lasts HALF_DIV cycles. adc_mosi changes only while the clock is low, and bits go out most significant first.
- R5: A write request sends the frame {4'h1, address, write data}, for example 0x1502 for data 0x02 to register 5.
- R6: A read request sends {4'h2, address, 8'h00} and then a second frame of all zeros. rd_data at done equals the last 8 bits sampled on adc_miso at rising clock edges in that second frame.
- R7: Exactly LEAD_CYC cycles pass from chip select falling to the first rising clock edge. Exactly LAG_CYC cycles pass from the last falling clock edge to chip select rising.
- R8: Chip select stays high for at least GAP_CYC cycles between any two frames, including between a read command and its dummy frame.
- R9: done is a one-cycle pulse issued after the last frame of a request, with req_ready high in that cycle. rd_data is 0 at the done of a write.
- R10: req_ready is low while uninitialised, during the reset and start-up sequence, and during any transaction. A req_valid or init_req that arrives while req_ready is low has no effect.
- R11: adc_convst is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| init_req | input | 1 | Start the converter reset and start-up sequence |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request port can accept |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, valid when done is high |
| adc_rst_n | output | 1 | Converter reset, active low |
| adc_convst | output | 1 | Converter convert-start, held inactive high |
| adc_cs_n | output | 1 | SPI chip select, active low |
| adc_sclk | output | 1 | SPI serial clock, idle low |
| adc_mosi | output | 1 | SPI data towards converter |
| adc_miso | input | 1 | SPI data from converter |

## Verification
The bench pits the design against a behavioural converter that returns register contents one frame late and puts a nonzero pattern in the upper byte. A design that read the wrong frame, or the wrong byte of the right one, would hand the host the pattern or a stale value. Phase lengths are timed on every clock. This catches a lead time cut short (the first capture comes too early after chip select), a missing gap before the dummy frame, and a reset or start-up interval off by one cycle. The bench also fires init_req in the middle of a read and sends requests before initialisation. A design that did not ignore these would cut a frame short or start frames before the converter was ready.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

   typedef enum logic [2:0] {
      SQ_UNINIT,
      SQ_RESET,
      SQ_BOOT,
      SQ_IDLE,
      SQ_CMD,
      SQ_DUMMY
   } seq_state_t;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_LEAD,
      FR_HIGH,
      FR_LOW,
      FR_LAG,
      FR_GAP
   } frame_phase_t;

   localparam int OPC_W = 4;
   localparam logic [OPC_W-1:0] OPC_WRITE = 4'h1;
   localparam logic [OPC_W-1:0] OPC_READ  = 4'h2;

endpackage

// File: rtl/adc_cfg_delay.sv
module adc_cfg_delay #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;
   logic             run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         cnt <= len - 1'b1;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);

endmodule

// File: rtl/adc_cfg_frame.sv
module adc_cfg_frame
   import adc_cfg_pkg::*;
#(
   parameter int FRAME_W  = 16,
   parameter int RX_KEEP  = 8,
   parameter int HALF_DIV = 12,
   parameter int LEAD_CYC = 4,
   parameter int LAG_CYC  = 4,
   parameter int GAP_CYC  = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               cs_n,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic [RX_KEEP-1:0] rx_word,
   output logic               fin
);

   localparam int M1      = (HALF_DIV > LEAD_CYC) ? HALF_DIV : LEAD_CYC;
   localparam int M2      = (LAG_CYC > GAP_CYC) ? LAG_CYC : GAP_CYC;
   localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   frame_phase_t       phase;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bidx;
   logic [FRAME_W-1:0] sh;
   logic [RX_KEEP-1:0] rx;
   logic               cs_q;
   logic               sclk_q;
   logic               fin_q;

   if (RX_KEEP < 2 || RX_KEEP > FRAME_W) begin : g_bad_rx
      $error("RX_KEEP must lie between 2 and FRAME_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= FR_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         sh     <= '0;
         rx     <= '0;
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         case (phase)
            FR_IDLE: begin
               if (start) begin
                  sh    <= tx_word;
                  cs_q  <= 1'b0;
                  bidx  <= '0;
                  cnt   <= CNT_W'(LEAD_CYC - 1);
                  phase <= FR_LEAD;
               end
            end
            FR_LEAD: begin
               if (cnt == '0) begin
                  sclk_q <= 1'b1;
                  rx     <= {rx[RX_KEEP-2:0], miso};
                  cnt    <= CNT_W'(HALF_DIV - 1);
                  phase  <= FR_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FR_HIGH: begin
               if (cnt == '0) begin
                  sclk_q <= 1'b0;
                  if (bidx == LAST_BIT) begin
                     cnt   <= CNT_W'(LAG_CYC - 1);
                     phase <= FR_LAG;
                  end else begin
                     sh    <= {sh[FRAME_W-2:0], 1'b0};
                     bidx  <= bidx + 1'b1;
                     cnt   <= CNT_W'(HALF_DIV - 1);
                     phase <= FR_LOW;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FR_LOW: begin
               if (cnt == '0) begin
                  sclk_q <= 1'b1;
                  rx     <= {rx[RX_KEEP-2:0], miso};
                  cnt    <= CNT_W'(HALF_DIV - 1);
                  phase  <= FR_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FR_LAG: begin
               if (cnt == '0) begin
                  cs_q  <= 1'b1;
                  cnt   <= CNT_W'(GAP_CYC - 1);
                  phase <= FR_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FR_GAP: begin
               if (cnt == '0) begin
                  phase <= FR_IDLE;
                  fin_q <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= FR_IDLE;
         endcase
      end
   end

   assign cs_n    = cs_q;
   assign sclk    = sclk_q;
   assign mosi    = sh[FRAME_W-1];
   assign rx_word = rx;
   assign fin     = fin_q;

endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
   import adc_cfg_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int SYS_CLK_PS = 4000,
   parameter int HALF_DIV   = 12,
   parameter int RST_CYC    = 68,
   parameter int BOOT_CYC   = 280,
   parameter int LEAD_CYC   = 4,
   parameter int LAG_CYC    = 4,
   parameter int GAP_CYC    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              adc_rst_n,
   output logic              adc_convst,
   output logic              adc_cs_n,
   output logic              adc_sclk,
   output logic              adc_mosi,
   input  logic              adc_miso
);

   localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
   localparam int TMR_MAX = (RST_CYC > BOOT_CYC) ? RST_CYC : BOOT_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   // elaboration-time limits, all in system clock cycles
   if (HALF_DIV < 1 || LAG_CYC < 1 || LEAD_CYC < 1) begin : g_bad_min
      $error("phase lengths must be at least one cycle");
   end
   if (LEAD_CYC * SYS_CLK_PS < 12000) begin : g_bad_lead
      $error("chip-select lead shorter than 12 ns");
   end
   if (RST_CYC * SYS_CLK_PS < 267000) begin : g_bad_rst
      $error("reset pulse shorter than 267 ns");
   end
   if (BOOT_CYC * SYS_CLK_PS < 1100000) begin : g_bad_boot
      $error("start-up wait shorter than 1.1 us");
   end
   if (2 * HALF_DIV * SYS_CLK_PS < 50000) begin : g_bad_sclk
      $error("serial clock faster than 20 MHz");
   end
   if (GAP_CYC < 2 * HALF_DIV) begin : g_bad_gap
      $error("chip-select gap shorter than one serial clock period");
   end
   if (FRAME_W > 32) begin : g_bad_frame
      $error("frame wider than 32 bits");
   end

   seq_state_t          state;
   logic                is_rd;
   logic                done_q;
   logic [DATA_W-1:0]   rd_q;
   logic                rst_q;

   logic                rst_go, boot_go, rst_exp, boot_exp;
   logic                acc, dummy_go, fr_start, fr_fin;
   logic [FRAME_W-1:0]  fr_tx;
   logic [DATA_W-1:0]   fr_rx;

   assign rst_go   = init_req && (state == SQ_UNINIT || state == SQ_IDLE);
   assign acc      = (state == SQ_IDLE) && req_valid && !init_req;
   assign boot_go  = (state == SQ_RESET) && rst_exp;
   assign dummy_go = (state == SQ_CMD) && fr_fin && is_rd;
   assign fr_start = acc || dummy_go;
   assign fr_tx    = acc ? {(req_write ? OPC_WRITE : OPC_READ), req_addr,
                            (req_write ? req_wdata : {DATA_W{1'b0}})}
                         : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_UNINIT;
         is_rd  <= 1'b0;
         done_q <= 1'b0;
         rd_q   <= '0;
         rst_q  <= 1'b1;
      end else begin
         done_q <= 1'b0;
         case (state)
            SQ_UNINIT, SQ_IDLE: begin
               if (rst_go) begin
                  rst_q <= 1'b0;
                  state <= SQ_RESET;
               end else if (acc) begin
                  is_rd <= !req_write;
                  state <= SQ_CMD;
               end
            end
            SQ_RESET: begin
               if (rst_exp) begin
                  rst_q <= 1'b1;
                  state <= SQ_BOOT;
               end
            end
            SQ_BOOT: begin
               if (boot_exp) state <= SQ_IDLE;
            end
            SQ_CMD: begin
               if (fr_fin) begin
                  if (is_rd) begin
                     state <= SQ_DUMMY;
                  end else begin
                     done_q <= 1'b1;
                     rd_q   <= '0;
                     state  <= SQ_IDLE;
                  end
               end
            end
            SQ_DUMMY: begin
               if (fr_fin) begin
                  done_q <= 1'b1;
                  rd_q   <= fr_rx;
                  state  <= SQ_IDLE;
               end
            end
            default: state <= SQ_UNINIT;
         endcase
      end
   end

   adc_cfg_delay #(.CNT_W(TMR_W)) u_rst_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (rst_go),
      .len     (TMR_W'(RST_CYC)),
      .expired (rst_exp)
   );

   adc_cfg_delay #(.CNT_W(TMR_W)) u_boot_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (boot_go),
      .len     (TMR_W'(BOOT_CYC)),
      .expired (boot_exp)
   );

   adc_cfg_frame #(
      .FRAME_W  (FRAME_W),
      .RX_KEEP  (DATA_W),
      .HALF_DIV (HALF_DIV),
      .LEAD_CYC (LEAD_CYC),
      .LAG_CYC  (LAG_CYC),
      .GAP_CYC  (GAP_CYC)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fr_start),
      .tx_word (fr_tx),
      .cs_n    (adc_cs_n),
      .sclk    (adc_sclk),
      .mosi    (adc_mosi),
      .miso    (adc_miso),
      .rx_word (fr_rx),
      .fin     (fr_fin)
   );

   assign req_ready  = (state == SQ_IDLE);
   assign done       = done_q;
   assign rd_data    = rd_q;
   assign adc_rst_n  = rst_q;
   assign adc_convst = 1'b1;

endmodule

// File: rtl/adc_cfg_seq_chk.sv
module adc_cfg_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic done,
   input logic adc_rst_n,
   input logic adc_cs_n,
   input logic adc_sclk,
   input logic adc_mosi
);

   assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk);

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi));

   assert_busy_noready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_cs_n |-> !req_ready);

   assert_rst_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rst_n |-> (adc_cs_n && !req_ready));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

bind adc_cfg_seq adc_cfg_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .adc_rst_n (adc_rst_n),
   .adc_cs_n  (adc_cs_n),
   .adc_sclk  (adc_sclk),
   .adc_mosi  (adc_mosi)
);

// File: tb/test_adc_cfg_seq.sv
module test_adc_cfg_seq;

   localparam int HALF = 12;
   localparam int RSTC = 68;
   localparam int BOOT = 280;
   localparam int LEAD = 4;
   localparam int LAG  = 4;
   localparam int GAP  = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_req = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_ready, done, adc_rst_n, adc_convst, adc_cs_n, adc_sclk, adc_mosi;
   logic [7:0] rd_data;
   logic       adc_miso = 1'b0;

   always #2 clk = ~clk;

   adc_cfg_seq i_adc_cfg_seq (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .rd_data(rd_data),
      .adc_rst_n(adc_rst_n), .adc_convst(adc_convst), .adc_cs_n(adc_cs_n),
      .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso)
   );

   int total = 0;
   int failed = 0;
   int cycles = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         finish_run();
      end
   end

   // behavioural converter and per-clock protocol monitor
   logic [7:0]  conv_regs [16];
   logic [7:0]  exp_regs  [16];
   logic [15:0] frames [$];
   logic [15:0] rxw, pending, miso_sh;
   logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_rst = 1'b1, prev_mosi = 1'b0, prev_done = 1'b0;
   int run_cnt = 0, bits = 0, gap_cnt = 0, had_frame = 0;
   int rst_low = 0, rst_falls = 0, boot_cnt = 0, boot_track = 0;
   int mosi_bad = 0, sclk_bad = 0, convst_bad = 0, busy_bad = 0;
   int dpulse_bad = 0, rst_cs_bad = 0, boot_cs_bad = 0, cs_low_seen = 0;

   initial begin
      for (int i = 0; i < 16; i++) begin
         conv_regs[i] = '0;
         exp_regs[i]  = '0;
      end
      pending = '0;
      miso_sh = '0;
      rxw     = '0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!adc_convst) convst_bad++;
         if (!adc_cs_n) cs_low_seen++;
         if (!adc_cs_n && req_ready) busy_bad++;
         if (done && prev_done) dpulse_bad++;
         if (!adc_rst_n) begin
            if (prev_rst) rst_falls++;
            rst_low++;
            if (!adc_cs_n || req_ready) rst_cs_bad++;
            for (int i = 0; i < 16; i++) conv_regs[i] = '0;
            pending = '0;
         end else if (!prev_rst) begin
            check(rst_low == RSTC, "R2 reset pulse width", rst_low, RSTC);
            rst_low = 0;
            boot_track = 1;
            boot_cnt = 1;
         end else if (boot_track != 0) begin
            if (req_ready) begin
               check(boot_cnt == BOOT, "R3 start-up wait", boot_cnt, BOOT);
               boot_track = 0;
            end else begin
               boot_cnt++;
            end
         end
         if (boot_track != 0 && !adc_cs_n) boot_cs_bad++;

         if (prev_cs && !adc_cs_n) begin
            if (had_frame != 0) check(gap_cnt >= GAP, "R8 chip-select gap", gap_cnt, GAP);
            bits = 0;
            run_cnt = 1;
            rxw = '0;
            miso_sh = pending;
            adc_miso = miso_sh[15];
         end else if (!adc_cs_n) begin
            if (!prev_sclk && adc_sclk) begin
               if (bits == 0) check(run_cnt == LEAD, "R7 lead time", run_cnt, LEAD);
               else           check(run_cnt == HALF, "R4 low phase", run_cnt, HALF);
               rxw = {rxw[14:0], adc_mosi};
               bits++;
               run_cnt = 1;
            end else if (prev_sclk && !adc_sclk) begin
               check(run_cnt == HALF, "R4 high phase", run_cnt, HALF);
               miso_sh = {miso_sh[14:0], 1'b0};
               adc_miso = miso_sh[15];
               run_cnt = 1;
            end else begin
               run_cnt++;
               if (adc_sclk && prev_sclk && adc_mosi != prev_mosi) mosi_bad++;
            end
         end else if (!prev_cs && adc_cs_n) begin
            check(run_cnt == LAG, "R7 lag time", run_cnt, LAG);
            check(bits == 16, "R4 edges per frame", bits, 16);
            frames.push_back(rxw);
            if (rxw[15:12] == 4'h1) conv_regs[rxw[11:8]] = rxw[7:0];
            if (rxw[15:12] == 4'h2) pending = {8'h5A, conv_regs[rxw[11:8]]};
            else                    pending = '0;
            adc_miso = 1'b0;
            gap_cnt = 1;
            had_frame = 1;
         end else begin
            gap_cnt++;
            if (adc_sclk) sclk_bad++;
         end
      end
      prev_cs   = adc_cs_n;
      prev_sclk = adc_sclk;
      prev_rst  = adc_rst_n;
      prev_mosi = adc_mosi;
      prev_done = done;
   end

   task automatic do_txn(input bit wr, input logic [3:0] a, input logic [7:0] d);
      logic [7:0] expv;
      frames.delete();
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      if (wr) begin
         exp_regs[a] = d;
         expv = 8'h00;
         check(frames.size() == 1, "R5 write frame count", frames.size(), 1);
         if (frames.size() >= 1)
            check(frames[0] == {4'h1, a, d}, "R5 write frame", frames[0], {4'h1, a, d});
         check(rd_data == 8'h00, "R9 write rd_data", rd_data, 0);
      end else begin
         expv = exp_regs[a];
         check(frames.size() == 2, "R6 read frame count", frames.size(), 2);
         if (frames.size() >= 2) begin
            check(frames[0] == {4'h2, a, 8'h00}, "R6 read command", frames[0], {4'h2, a, 8'h00});
            check(frames[1] == 16'h0000, "R6 dummy frame", frames[1], 0);
         end
         check(rd_data == expv, "R6 read data", rd_data, expv);
      end
      check(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
      @(negedge clk);
      check(done == 1'b0, "R9 done width", done, 0);
   endtask

   initial begin
      int falls0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(adc_rst_n && adc_cs_n && !adc_sclk && adc_convst && !req_ready && !done,
            "R1 reset state",
            {adc_rst_n, adc_cs_n, adc_sclk, adc_convst, req_ready, done}, 6'b110100);

      // R10: requests before initialisation are ignored
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = 4'h5;
      req_wdata = 8'h77;
      repeat (40) @(negedge clk);
      req_valid = 1'b0;
      check(cs_low_seen == 0 && !req_ready, "R10 request before init", cs_low_seen, 0);

      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      check(!adc_rst_n && !req_ready, "R2 reset asserted", {adc_rst_n, req_ready}, 0);
      while (!req_ready) @(negedge clk);
      check(rst_falls == 1, "R2 one reset pulse", rst_falls, 1);

      do_txn(1'b1, 4'h5, 8'h02);
      do_txn(1'b0, 4'h5, 8'h00);
      do_txn(1'b1, 4'h0, 8'hFF);
      do_txn(1'b1, 4'hF, 8'h80);
      do_txn(1'b0, 4'hF, 8'h00);
      do_txn(1'b0, 4'h0, 8'h00);
      do_txn(1'b0, 4'h9, 8'h00);
      do_txn(1'b1, 4'h3, 8'h3C);
      do_txn(1'b0, 4'h3, 8'h00);

      // R10: init_req in the middle of a read has no effect
      falls0 = rst_falls;
      fork
         do_txn(1'b0, 4'h5, 8'h00);
         begin
            repeat (150) @(negedge clk);
            init_req = 1'b1;
            @(negedge clk);
            init_req = 1'b0;
         end
      join
      check(rst_falls == falls0, "R10 init ignored while busy", rst_falls, falls0);

      // R2: re-initialisation from idle resets the converter
      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      for (int i = 0; i < 16; i++) exp_regs[i] = '0;
      while (!req_ready) @(negedge clk);
      check(rst_falls == falls0 + 1, "R2 re-init pulse", rst_falls, falls0 + 1);
      do_txn(1'b0, 4'h5, 8'h00);
      do_txn(1'b1, 4'h7, 8'hA6);
      do_txn(1'b0, 4'h7, 8'h00);

      repeat (10) @(negedge clk);
      check(mosi_bad == 0, "R4 mosi stable while clock high", mosi_bad, 0);
      check(sclk_bad == 0, "R4 clock low while deselected", sclk_bad, 0);
      check(convst_bad == 0, "R11 convert-start high", convst_bad, 0);
      check(busy_bad == 0, "R10 ready low during frame", busy_bad, 0);
      check(dpulse_bad == 0, "R9 done single cycle", dpulse_bad, 0);
      check(rst_cs_bad == 0, "R2 quiet during reset", rst_cs_bad, 0);
      check(boot_cs_bad == 0, "R3 no frame during start-up", boot_cs_bad, 0);
      finish_run();
   end

endmodule